// File: doc/BRIEF.md
# Aliased Vector / Floating-Point Register File

This block holds 32 floating-point entries of 82 bits each: a sign bit (81), a 17-bit exponent (80:64) and a 64-bit mantissa (63:0). The file can be reached through two views. The floating-point view has one synchronous write port and one combinational read port. Each of these ports moves a whole 82-bit entry.

The vector view presents eight 128-bit registers, again with one synchronous write port and one combinational read port. Vector register n lives in the mantissas of two entries in the upper half of the file. Its low 64 bits sit in entry 16+2n and its high 64 bits sit in entry 17+2n. A vector write stamps a constant exponent of 17'h1003E and a zero sign into both target entries. A vector read takes only the two mantissas and ignores whatever the upper fields hold.

Both views share one storage array, so a write through either view is seen at once by the other. When the two write ports hit the same entry in one cycle, the vector write takes that entry.

Top module: `aliased_regfile_top`

## Requirements
- R1: A synchronous active-high reset clears all 32 entries to zero, so both read ports then return zero.
- R2: A floating-point write with `fpWrEn` high stores all 82 bits of `fpWrData` at `fpWrAddr` (any of entries 0 to 31). From the next cycle on, reading that address returns the same 82 bits.
- R3: A vector write of register n places data bits 63:0 in mantissa bits 63:0 of entry 16+2n, and data bits 127:64 in mantissa bits 63:0 of entry 17+2n.
- R4: A vector write sets bits 80:64 of both target entries to 17'h1003E and clears bit 81 of both. A floating-point read of either entry then returns {1'b0, 17'h1003E, data half}.
- R5: A vector read of register n returns {entry(17+2n)[63:0], entry(16+2n)[63:0]}. Bits 81:64 of those entries have no effect, whatever they hold.
- R6: Vector writes never change entries 0 through 15.
- R7: A floating-point write to entry 16+2n or 17+2n changes the low or high half of vector register n to that write's bits 63:0.
- R8: When both ports write the same entry in one cycle, the entry takes the vector value. A floating-point write to an entry outside the vector target pair still takes effect in that cycle.
- R9: Reads show the contents as of the last clock edge. A write in the current cycle is not forwarded to either read port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fpWrEn | input | 1 | Floating-point view write enable |
| fpWrAddr | input | 5 | Floating-point view write entry |
| fpWrData | input | 82 | Floating-point view write data |
| fpRdAddr | input | 5 | Floating-point view read entry |
| fpRdData | output | 82 | Floating-point view read data |
| vecWrEn | input | 1 | Vector view write enable |
| vecWrAddr | input | 3 | Vector register to write |
| vecWrData | input | 128 | Vector view write data |
| vecRdAddr | input | 3 | Vector register to read |
| vecRdData | output | 128 | Vector view read data |

## Verification
The bench places entries holding sign 1 and an all-ones exponent under a vector register. A design that leaked the upper fields into a vector read would return corrupted halves. It drives same-cycle writes on both ports, both to the same entry and to the other entry of the pair; a wrong priority leaves floating-point data where the stamped vector value belongs. It fills entries 0 to 15 and then writes every vector register, which catches an off-by-one in the pair mapping that spills into the lower half. It also reads each address in the same cycle that address is written, to catch a design that forwards write data early.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int NUM_ENTRIES = 32;
  localparam int MANT_W      = 64;
  localparam int EXP_W       = 17;
  localparam int ENTRY_W     = 1 + EXP_W + MANT_W;
  localparam int VEC_REGS    = 8;
  localparam int ALIAS_BASE  = 16;
  localparam int VEC_W       = 2 * MANT_W;
  localparam int FP_ADDR_W   = $clog2(NUM_ENTRIES);
  localparam int VEC_ADDR_W  = $clog2(VEC_REGS);
  localparam logic [EXP_W-1:0] FORCED_EXP = 17'h1003E;

  // Per-entry strobes from control to the datapath
  typedef struct packed {
    logic                   clrAll;
    logic [NUM_ENTRIES-1:0] fpWe;
    logic [NUM_ENTRIES-1:0] vecWe;
  } wrStrobes_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
#(
  parameter int NENT  = NUM_ENTRIES,
  parameter int NVEC  = VEC_REGS,
  parameter int BASE  = ALIAS_BASE,
  parameter int FAW   = FP_ADDR_W,
  parameter int VAW   = VEC_ADDR_W
) (
  input  logic           rst,
  input  logic           fpWrEn,
  input  logic [FAW-1:0] fpWrAddr,
  input  logic           vecWrEn,
  input  logic [VAW-1:0] vecWrAddr,
  output wrStrobes_t     strobes
);
  logic [NENT-1:0] fpWeVec;
  logic [NENT-1:0] vecWeVec;

  for (genvar i = 0; i < NENT; i++) begin : gDecode
    logic fpHit;
    assign fpHit = fpWrEn && (fpWrAddr == FAW'(i));
    if (i >= BASE && i < BASE + 2 * NVEC) begin : gAliased
      localparam logic [VAW-1:0] PAIR_IDX = VAW'((i - BASE) / 2);
      logic vecHit;
      assign vecHit      = vecWrEn && (vecWrAddr == PAIR_IDX);
      // vector port owns the entry on a collision
      assign vecWeVec[i] = vecHit;
      assign fpWeVec[i]  = fpHit && !vecHit;
    end else begin : gPlain
      assign vecWeVec[i] = 1'b0;
      assign fpWeVec[i]  = fpHit;
    end
  end

  assign strobes = '{clrAll: rst, fpWe: fpWeVec, vecWe: vecWeVec};
endmodule

// File: rtl/regfile_dpath.sv
module regfile_dpath
  import regfile_pkg::*;
#(
  parameter int NENT  = NUM_ENTRIES,
  parameter int NVEC  = VEC_REGS,
  parameter int BASE  = ALIAS_BASE,
  parameter int MW    = MANT_W,
  parameter int EW    = EXP_W,
  parameter int FAW   = FP_ADDR_W,
  parameter int VAW   = VEC_ADDR_W,
  parameter logic [EXP_W-1:0] STAMP_EXP = FORCED_EXP
) (
  input  logic                  clk,
  input  wrStrobes_t            strobes,
  input  logic [1+EW+MW-1:0]    fpWrData,
  input  logic [2*MW-1:0]       vecWrData,
  input  logic [FAW-1:0]        fpRdAddr,
  input  logic [VAW-1:0]        vecRdAddr,
  output logic [1+EW+MW-1:0]    fpRdData,
  output logic [2*MW-1:0]       vecRdData
);
  localparam int EWIDTH = 1 + EW + MW;

  logic [NENT-1:0][EWIDTH-1:0] entryQ;

  for (genvar i = 0; i < NENT; i++) begin : gEntry
    logic [EWIDTH-1:0] q;
    if (i >= BASE && i < BASE + 2 * NVEC) begin : gAliased
      localparam int HALF = (i - BASE) % 2;
      logic [MW-1:0] vecHalf;
      assign vecHalf = vecWrData[HALF*MW +: MW];
      always_ff @(posedge clk) begin
        if (strobes.clrAll)         q <= '0;
        else if (strobes.vecWe[i])  q <= {1'b0, STAMP_EXP, vecHalf};
        else if (strobes.fpWe[i])   q <= fpWrData;
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (strobes.clrAll)         q <= '0;
        else if (strobes.fpWe[i])   q <= fpWrData;
      end
    end
    assign entryQ[i] = q;
  end

  assign fpRdData = entryQ[fpRdAddr];

  always_comb begin
    vecRdData = '0;
    for (int h = 0; h < 2; h++) begin
      vecRdData[h*MW +: MW] =
        entryQ[FAW'(BASE + 2 * int'(vecRdAddr) + h)][MW-1:0];
    end
  end
endmodule

// File: rtl/aliased_regfile_top.sv
module aliased_regfile_top
  import regfile_pkg::*;
#(
  parameter int NENT = NUM_ENTRIES,
  parameter int NVEC = VEC_REGS,
  parameter int BASE = ALIAS_BASE,
  parameter int MW   = MANT_W,
  parameter int EW   = EXP_W,
  parameter int FAW  = FP_ADDR_W,
  parameter int VAW  = VEC_ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fpWrEn,
  input  logic [FAW-1:0]       fpWrAddr,
  input  logic [1+EW+MW-1:0]   fpWrData,
  input  logic [FAW-1:0]       fpRdAddr,
  output logic [1+EW+MW-1:0]   fpRdData,
  input  logic                 vecWrEn,
  input  logic [VAW-1:0]       vecWrAddr,
  input  logic [2*MW-1:0]      vecWrData,
  input  logic [VAW-1:0]       vecRdAddr,
  output logic [2*MW-1:0]      vecRdData
);
  wrStrobes_t strobes;

  regfile_ctrl #(
    .NENT(NENT), .NVEC(NVEC), .BASE(BASE), .FAW(FAW), .VAW(VAW)
  ) uCtrl (
    .rst(rst), .fpWrEn(fpWrEn), .fpWrAddr(fpWrAddr),
    .vecWrEn(vecWrEn), .vecWrAddr(vecWrAddr), .strobes(strobes)
  );

  regfile_dpath #(
    .NENT(NENT), .NVEC(NVEC), .BASE(BASE), .MW(MW), .EW(EW),
    .FAW(FAW), .VAW(VAW), .STAMP_EXP(FORCED_EXP)
  ) uDpath (
    .clk(clk), .strobes(strobes), .fpWrData(fpWrData), .vecWrData(vecWrData),
    .fpRdAddr(fpRdAddr), .vecRdAddr(vecRdAddr),
    .fpRdData(fpRdData), .vecRdData(vecRdData)
  );
endmodule

// File: rtl/regfile_checker.sv
module regfile_checker
  import regfile_pkg::*;
(
  input logic                   clk,
  input logic                   rst,
  input logic                   fpWrEn,
  input logic [FP_ADDR_W-1:0]   fpWrAddr,
  input logic [ENTRY_W-1:0]     fpWrData,
  input logic [FP_ADDR_W-1:0]   fpRdAddr,
  input logic [ENTRY_W-1:0]     fpRdData,
  input logic                   vecWrEn,
  input logic [VEC_ADDR_W-1:0]  vecWrAddr,
  input logic [VEC_W-1:0]       vecWrData,
  input logic [VEC_ADDR_W-1:0]  vecRdAddr,
  input logic [VEC_W-1:0]       vecRdData
);
  logic fpCollide;
  assign fpCollide = vecWrEn && (int'(fpWrAddr) >= ALIAS_BASE) &&
                     (((int'(fpWrAddr) - ALIAS_BASE) / 2) == int'(vecWrAddr));

  // R1: reset empties the file
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (fpRdData == '0 && vecRdData == '0));

  // R2: uncontested floating-point write reads back whole
  p_fp_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (fpWrEn && !fpCollide) |=>
      ((fpRdAddr != $past(fpWrAddr)) || (fpRdData == $past(fpWrData))));

  // R3/R4: low entry of pair is stamped and holds data bits 63:0
  p_vec_low_stamp_r4: assert property (@(posedge clk) disable iff (rst)
    vecWrEn |=>
      ((int'(fpRdAddr) != ALIAS_BASE + 2 * int'($past(vecWrAddr))) ||
       (fpRdData == {1'b0, FORCED_EXP, $past(vecWrData[MANT_W-1:0])})));

  // R3/R4: high entry of pair is stamped and holds data bits 127:64
  p_vec_high_stamp_r3: assert property (@(posedge clk) disable iff (rst)
    vecWrEn |=>
      ((int'(fpRdAddr) != ALIAS_BASE + 2 * int'($past(vecWrAddr)) + 1) ||
       (fpRdData == {1'b0, FORCED_EXP, $past(vecWrData[VEC_W-1:MANT_W])})));

  // R8/R5: vector write reads back intact, even against a same-cycle fp write
  p_vec_wins_r8: assert property (@(posedge clk) disable iff (rst)
    vecWrEn |=>
      ((vecRdAddr != $past(vecWrAddr)) || (vecRdData == $past(vecWrData))));

  // R6: lower entries stay put without a floating-point write
  p_low_untouched_r6: assert property (@(posedge clk) disable iff (rst)
    (!fpWrEn && int'(fpRdAddr) < ALIAS_BASE) |=>
      ((fpRdAddr != $past(fpRdAddr)) || $stable(fpRdData)));
endmodule

bind aliased_regfile_top regfile_checker uChk (.*);

// File: tb/tb_aliased_regfile_top.sv
`timescale 1ns/1ps
module tb_aliased_regfile_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fpWrEn = 1'b0;
  logic [4:0]   fpWrAddr = '0;
  logic [81:0]  fpWrData = '0;
  logic [4:0]   fpRdAddr = '0;
  logic [81:0]  fpRdData;
  logic         vecWrEn = 1'b0;
  logic [2:0]   vecWrAddr = '0;
  logic [127:0] vecWrData = '0;
  logic [2:0]   vecRdAddr = '0;
  logic [127:0] vecRdData;

  always #2 clk = ~clk;

  aliased_regfile_top dut (.*);

  typedef struct {
    logic [81:0]  fpExp;
    logic [127:0] vecExp;
    string        tag;
  } item_t;

  item_t        sbq[$];
  logic [81:0]  model [32];
  int           compared = 0;
  int           mismatched = 0;
  bit           rstReq = 1'b1;
  bit           finished = 1'b0;

  function automatic logic [127:0] vecOf(input int n);
    return {model[17 + 2 * n][63:0], model[16 + 2 * n][63:0]};
  endfunction

  // driver: one clock per call; expectation is the pre-edge state (R9)
  task automatic step(input bit fwe, input int fwa, input logic [81:0] fwd,
                      input bit vwe, input int vwa, input logic [127:0] vwd,
                      input int fra, input int vra, input string tag,
                      input bit chk = 1'b1);
    item_t it;
    @(negedge clk);
    rst = rstReq;
    fpWrEn = fwe; fpWrAddr = 5'(fwa); fpWrData = fwd;
    vecWrEn = vwe; vecWrAddr = 3'(vwa); vecWrData = vwd;
    fpRdAddr = 5'(fra); vecRdAddr = 3'(vra);
    if (chk && !rstReq) begin
      it.fpExp = model[fra]; it.vecExp = vecOf(vra); it.tag = tag;
      sbq.push_back(it);
    end
    if (rstReq) begin
      for (int k = 0; k < 32; k++) model[k] = '0;
    end else begin
      if (fwe) model[fwa] = fwd;
      if (vwe) begin
        model[16 + 2 * vwa] = {1'b0, 17'h1003E, vwd[63:0]};
        model[17 + 2 * vwa] = {1'b0, 17'h1003E, vwd[127:64]};
      end
    end
  endtask

  task automatic rd(input int fra, input int vra, input string tag);
    step(1'b0, 0, '0, 1'b0, 0, '0, fra, vra, tag);
  endtask

  // monitor: compares just before the next edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        compared += 2;
        if (fpRdData !== it.fpExp) begin
          mismatched++;
          $display("FAIL %s fp read: actual %h expected %h", it.tag, fpRdData, it.fpExp);
        end
        if (vecRdData !== it.vecExp) begin
          mismatched++;
          $display("FAIL %s vec read: actual %h expected %h", it.tag, vecRdData, it.vecExp);
        end
      end
    end
  end

  function automatic logic [127:0] vpat(input int n, input int salt);
    return {32'(n * 32'h9E3779B9 + salt), 32'hC0DE0000 + 32'(n), 32'(salt * 7 + 1), 32'h5A5A0000 + 32'(n)};
  endfunction

  initial begin
    for (int k = 0; k < 32; k++) model[k] = '0;
    rstReq = 1'b1;
    step(1'b0, 0, '0, 1'b0, 0, '0, 0, 0, "", 1'b0);
    step(1'b0, 0, '0, 1'b0, 0, '0, 0, 0, "", 1'b0);
    rstReq = 1'b0;

    // R1: reset state
    rd(0, 0, "R1"); rd(15, 3, "R1"); rd(16, 7, "R1"); rd(31, 5, "R1");

    // R2 + R9: full-width fp writes, read in same cycle then after
    for (int j = 0; j < 5; j++) begin
      int a;
      logic [81:0] d;
      a = (j == 0) ? 0 : (j == 1) ? 5 : (j == 2) ? 15 : (j == 3) ? 16 : 31;
      d = {1'b1, 17'(32'h1A5A5 + j), 64'hFEDC_BA98_0000_0000 + 64'(j * 3 + 1)};
      step(1'b1, a, d, 1'b0, 0, '0, a, 0, "R9");
      rd(a, 0, "R2");
    end

    // R3/R4: every vector register, checked through both views
    for (int n = 0; n < 8; n++) step(1'b0, 0, '0, 1'b1, n, vpat(n, 1), 0, n, "R9");
    for (int n = 0; n < 8; n++) begin
      rd(16 + 2 * n, n, "R3");
      rd(17 + 2 * n, n, "R4");
    end

    // R5: upper fields full of special encodings are ignored
    step(1'b1, 18, {1'b1, 17'h1FFFF, 64'h0123_4567_89AB_CDEF}, 1'b0, 0, '0, 0, 1, "R5");
    step(1'b1, 19, {1'b1, 17'h00000, 64'h0BAD_F00D_1234_5678}, 1'b0, 0, '0, 18, 1, "R5");
    rd(19, 1, "R5");

    // R6: lower half survives every vector write
    for (int k = 0; k < 16; k++)
      step(1'b1, k, {1'b0, 17'(k), 64'hAAAA_0000_0000_0000 + 64'(k)}, 1'b0, 0, '0, 0, 0, "R6", 1'b0);
    for (int n = 0; n < 8; n++) step(1'b0, 0, '0, 1'b1, n, vpat(n, 9), 15 - n, n, "R6");
    for (int k = 0; k < 16; k++) rd(k, k % 8, "R6");

    // R7: fp write lands in the matching vector half
    step(1'b1, 21, {1'b1, 17'h0ABCD, 64'h7777_6666_5555_4444}, 1'b0, 0, '0, 0, 2, "R7");
    rd(21, 2, "R7");
    step(1'b1, 26, {1'b0, 17'h00001, 64'h1111_2222_3333_4444}, 1'b0, 0, '0, 0, 5, "R7");
    rd(26, 5, "R7");

    // R8: collisions between the two write ports
    step(1'b1, 20, {1'b1, 17'h1FFFF, 64'hDEAD_DEAD_DEAD_DEAD}, 1'b1, 2, vpat(2, 33), 0, 0, "R8");
    rd(20, 2, "R8");
    step(1'b1, 23, {1'b1, 17'h12345, 64'hBEEF_BEEF_BEEF_BEEF}, 1'b1, 3, vpat(3, 44), 22, 3, "R8");
    rd(23, 3, "R8");
    step(1'b1, 9, {1'b1, 17'h05555, 64'h9999_8888_7777_6666}, 1'b1, 4, vpat(4, 55), 0, 0, "R8");
    rd(9, 4, "R8");
    step(1'b1, 30, {1'b0, 17'h00042, 64'h4242_4242_4242_4242}, 1'b1, 0, vpat(0, 66), 0, 0, "R8");
    rd(30, 7, "R8");
    rd(16, 0, "R8");

    // R1: reset in the middle of a run
    rstReq = 1'b1;
    step(1'b1, 3, '1, 1'b1, 6, '1, 0, 0, "", 1'b0);
    rstReq = 1'b0;
    rd(3, 6, "R1"); rd(28, 6, "R1"); rd(9, 4, "R1");

    repeat (3) @(negedge clk);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule